// File: doc/BRIEF.md
# Six-Channel Compare Timer

A bank of independent up-counting timer channels behind a flat word-addressed register port. Each channel takes one of two tick-enable inputs, a fast system tick or a slow low-rate tick, and can halve that rate. It counts while enabled and compares its count against a programmable value. On a match it raises a sticky pending flag. The channel then stops (one-shot), restarts from zero (repeat), or keeps counting through the match and wraps at the top of its range (free-running).

A shared pair of registers sets which channels may drive the single interrupt line and clears pending flags by writing ones. Writes take effect at the clock edge on which `reg_wr` is sampled high. Reads are combinational from the registered state. Address bits [1:0] are ignored.

Top module: `ctmr_top`

## Requirements
- R1: After reset every register reads 0, every channel is disabled and `irq` is low.
- R2: Word 0x00 holds the interrupt enables and word 0x08 the pending flags, with channel n (1..NUM_CH) on bit n-1. Channel n owns words 0x10*n + {0x0 control, 0x4 clock select, 0x8 count, 0xC compare}. The compare value reads back as written, within CNT_W bits. Any other address reads 0.
- R3: Control bit 0 is the channel enable and bits 5:4 the mode; both read back as written. Writing 1 to control bit 1 zeroes the count and the halving phase, and that bit always reads 0.
- R4: An enabled channel adds one to its count per selected tick; a disabled channel keeps its count.
- R5: Clock-select bit 4 picks the system tick (0) or the slow tick (1). Clock-select bit 0 set makes the channel count on every second selected tick, the first count coming on the second tick after a clear.
- R6: In mode 0 (one-shot), a tick that brings the count to the compare value leaves the count at that value, clears control bit 0 and sets the pending flag.
- R7: In mode 1 (repeat), a tick that would bring the count to the compare value sets the count to 0 instead, sets the pending flag and keeps the channel enabled.
- R8: In mode 3, and also mode 2, the count passes through the compare value (setting the pending flag) and wraps from all ones to 0.
- R9: A match sets the pending flag whether or not that channel's interrupt enable is set.
- R10: Writing word 0x08 clears each pending flag whose data bit is 1 and leaves the others. A match in the same cycle as its acknowledge keeps the flag set.
- R11: `irq` is high exactly when some channel has both its pending flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sys | input | 1 | Fast tick enable, one cycle per tick |
| tick_slow | input | 1 | Slow tick enable, one cycle per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The count path is driven with system ticks only, slow ticks only, and slow ticks with halving. Counting on the wrong source, or on the wrong phase of the halver, shows up as a count off by a known amount. The match is tried in all three mode codes plus the spare code 2, so stopping, restarting and passing through can be told apart by the count and the control readback one tick after the match. The free-running channel is run past its top value to separate a wrap from saturation. A tick and an acknowledge in the same cycle separate set-over-clear priority from clear-over-set.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        MODE_ONCE     = 2'd0,
        MODE_LOOP     = 2'd1,
        MODE_FREE_ALT = 2'd2,
        MODE_FREE     = 2'd3
    } ctmr_mode_e;

    // word index inside a 16-byte slot
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_CLK  = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;
    localparam logic [1:0] OFS_CMP  = 2'd3;
    localparam logic [1:0] OFS_IEN  = 2'd0;
    localparam logic [1:0] OFS_ACK  = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CLK_SRC_BIT   = 4;
    localparam int CLK_HALF_BIT  = 0;

endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_sys,
    input  logic tick_slow,
    input  logic use_slow,
    input  logic halve,
    input  logic run,
    input  logic restart,
    output logic step
);

    typedef struct packed {
        logic phase;
    } ps_state_t;

    ps_state_t ps_d, ps_q;
    logic      raw;

    always_comb begin
        ps_d = ps_q;
        step = 1'b0;
        raw  = use_slow ? tick_slow : tick_sys;
        if (restart) begin
            ps_d.phase = 1'b0;
        end else if (run && raw) begin
            if (halve) begin
                step       = ps_q.phase;
                ps_d.phase = ~ps_q.phase;
            end else begin
                step = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys,
    input  logic              tick_slow,
    input  logic              wr_ctrl,
    input  logic              wr_clk,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic [1:0]        mode,
    output logic              use_slow,
    output logic              halve,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              match
);

    typedef struct packed {
        logic             en;
        ctmr_mode_e       mode;
        logic             use_slow;
        logic             halve;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } ch_state_t;

    ch_state_t        ch_d, ch_q;
    logic             step;
    logic             restart;
    logic [CNT_W-1:0] cnt_inc;

    assign restart = wr_ctrl && wdata[CTRL_CLR_BIT];

    ctmr_prescale ps_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sys  (tick_sys),
        .tick_slow (tick_slow),
        .use_slow  (ch_q.use_slow),
        .halve     (ch_q.halve),
        .run       (ch_q.en),
        .restart   (restart),
        .step      (step)
    );

    always_comb begin
        ch_d    = ch_q;
        match   = 1'b0;
        cnt_inc = ch_q.cnt + CNT_W'(1);

        if (step) begin
            match = (cnt_inc == ch_q.cmp);
            if (match && ch_q.mode == MODE_ONCE) begin
                ch_d.cnt = cnt_inc;
                ch_d.en  = 1'b0;
            end else if (match && ch_q.mode == MODE_LOOP) begin
                ch_d.cnt = '0;
            end else begin
                ch_d.cnt = cnt_inc;
            end
        end

        if (wr_clk) begin
            ch_d.use_slow = wdata[CLK_SRC_BIT];
            ch_d.halve    = wdata[CLK_HALF_BIT];
        end
        if (wr_cmp) begin
            ch_d.cmp = wdata[CNT_W-1:0];
        end
        if (wr_ctrl) begin
            ch_d.en   = wdata[CTRL_EN_BIT];
            ch_d.mode = ctmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
            if (wdata[CTRL_CLR_BIT]) ch_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign en       = ch_q.en;
    assign mode     = ch_q.mode;
    assign use_slow = ch_q.use_slow;
    assign halve    = ch_q.halve;
    assign cnt      = ch_q.cnt;
    assign cmp      = ch_q.cmp;

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys,
    input  logic              tick_slow,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int SLOT_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0] ien;
        logic [NUM_CH-1:0] pend;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        word;
    logic              wr_ien;
    logic              wr_ack;

    logic [NUM_CH-1:0]            wr_ctrl, wr_clk, wr_cmp;
    logic [NUM_CH-1:0]            ch_en, ch_slow, ch_half, ch_match;
    logic [NUM_CH-1:0][1:0]       ch_mode;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_cmp;
    logic [NUM_CH-1:0]            pend_now, ien_now;

    assign slot   = reg_addr[ADDR_W-1:4];
    assign word   = reg_addr[3:2];
    assign wr_ien = reg_wr && slot == '0 && word == OFS_IEN;
    assign wr_ack = reg_wr && slot == '0 && word == OFS_ACK;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit        = reg_wr && slot == SLOT_W'(g + 1);
        assign wr_ctrl[g] = hit && word == OFS_CTRL;
        assign wr_clk[g]  = hit && word == OFS_CLK;
        assign wr_cmp[g]  = hit && word == OFS_CMP;

        ctmr_channel #(.CNT_W(CNT_W)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_sys  (tick_sys),
            .tick_slow (tick_slow),
            .wr_ctrl   (wr_ctrl[g]),
            .wr_clk    (wr_clk[g]),
            .wr_cmp    (wr_cmp[g]),
            .wdata     (reg_wdata),
            .en        (ch_en[g]),
            .mode      (ch_mode[g]),
            .use_slow  (ch_slow[g]),
            .halve     (ch_half[g]),
            .cnt       (ch_cnt[g]),
            .cmp       (ch_cmp[g]),
            .match     (ch_match[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (wr_ien) top_d.ien  = reg_wdata[NUM_CH-1:0];
        if (wr_ack) top_d.pend = top_q.pend & ~reg_wdata[NUM_CH-1:0];
        top_d.pend = top_d.pend | ch_match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign pend_now = top_q.pend;
    assign ien_now  = top_q.ien;
    assign irq      = |(top_q.pend & top_q.ien);

    always_comb begin
        reg_rdata = '0;
        if (slot == '0) begin
            case (word)
                OFS_IEN: reg_rdata = DATA_W'(top_q.ien);
                OFS_ACK: reg_rdata = DATA_W'(top_q.pend);
                default: reg_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                case (word)
                    OFS_CTRL: reg_rdata = DATA_W'({ch_mode[i], 3'b000, ch_en[i]});
                    OFS_CLK:  reg_rdata = DATA_W'({ch_slow[i], 3'b000, ch_half[i]});
                    OFS_CNT:  reg_rdata = DATA_W'(ch_cnt[i]);
                    default:  reg_rdata = DATA_W'(ch_cmp[i]);
                endcase
            end
        end
    end

endmodule

// File: rtl/ctmr_top_chk.sv
module ctmr_top_chk
    import ctmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ch_match,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0][1:0]       ch_mode,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]            pend_now
);

    logic wr_ien_all0, wr_ack_all1;
    assign wr_ien_all0 = reg_wr && reg_addr[ADDR_W-1:2] == '0
                         && reg_wdata[NUM_CH-1:0] == '0;
    assign wr_ack_all1 = reg_wr && reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(2)
                         && (&reg_wdata[NUM_CH-1:0]);

    // R11: clearing every enable drops the line on the next cycle
    a_r11_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien_all0 |=> !irq);

    // R9: a match always leaves its pending flag set
    a_r9_match_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_match != '0) |=> ((pend_now & $past(ch_match)) == $past(ch_match)));

    // R10: acknowledging all with no match in flight empties the flags
    a_r10_ack_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack_all1 && ch_match == '0) |=> (pend_now == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(16 * (g + 1));
        logic wr_ctl;
        assign wr_ctl = reg_wr && reg_addr[ADDR_W-1:2] == CTRL_A[ADDR_W-1:2];

        // R6: one-shot match drops the enable
        a_r6_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_match[g] && ch_mode[g] == 2'd0 && !wr_ctl) |=> !ch_en[g]);

        // R7: repeat match restarts the count
        a_r7_loop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_match[g] && ch_mode[g] == 2'd1 && !wr_ctl) |=> (ch_cnt[g] == '0));

        // R4: a disabled channel keeps its count
        a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[g] && !wr_ctl) |=> $stable(ch_cnt[g]));
    end

endmodule

bind ctmr_top ctmr_top_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;

    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sys = 1'b0;
    logic        tick_slow = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctmr_top #(.NUM_CH(6), .CNT_W(10)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_sys  (tick_sys),
        .tick_slow (tick_slow),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // {read, addr, data}: a read compares reg_rdata against data
    localparam logic [40:0] VECS [NV] = '{
        {1'b0, 8'h1C, 32'h155}, {1'b1, 8'h1C, 32'h155},   // R2 compare
        {1'b0, 8'h24, 32'h11},  {1'b1, 8'h24, 32'h11},    // R5 clock select
        {1'b0, 8'h24, 32'h00},  {1'b1, 8'h24, 32'h00},
        {1'b0, 8'h30, 32'h30},  {1'b1, 8'h30, 32'h30},    // R3 mode bits
        {1'b0, 8'h30, 32'h32},  {1'b1, 8'h30, 32'h30},    // R3 clear reads 0
        {1'b0, 8'h30, 32'h00},
        {1'b0, 8'h00, 32'h3F},  {1'b1, 8'h00, 32'h3F},    // R2 enables
        {1'b0, 8'h00, 32'h00},
        {1'b1, 8'h04, 32'h00},  {1'b1, 8'h70, 32'h00},    // R2 unmapped
        {1'b1, 8'h6C, 32'h00},  {1'b1, 8'h08, 32'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic sys_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_sys = 1'b1;
            @(negedge clk); tick_sys = 1'b0;
        end
    endtask

    task automatic slow_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_slow = 1'b1;
            @(negedge clk); tick_slow = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1", 8'h00, 32'h0);
        rd("R1", 8'h08, 32'h0);
        rd("R1", 8'h10, 32'h0);
        rd("R1", 8'h38, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v][40]) rd("R2/R3/R5 table", VECS[v][39:32], VECS[v][31:0]);
            else             wr(VECS[v][39:32], VECS[v][31:0]);
        end

        // R4 / R5 channel 1: system tick, no halving
        wr(8'h1C, 32'd100); wr(8'h14, 32'h0); wr(8'h10, 32'h31);
        sys_ticks(5);
        rd("R4 count", 8'h18, 32'd5);
        slow_ticks(3);
        rd("R5 other source ignored", 8'h18, 32'd5);
        wr(8'h10, 32'h30);
        sys_ticks(3);
        rd("R4 disabled holds", 8'h18, 32'd5);
        wr(8'h10, 32'h32);
        rd("R3 clear", 8'h18, 32'd0);
        rd("R3 clear bit reads 0", 8'h10, 32'h30);

        // R5 channel 2: slow tick, halved
        wr(8'h2C, 32'd200); wr(8'h24, 32'h11); wr(8'h20, 32'h31);
        sys_ticks(3);
        rd("R5 slow source", 8'h28, 32'd0);
        slow_ticks(5);
        rd("R5 halved", 8'h28, 32'd2);
        wr(8'h20, 32'h0);

        // R6 channel 3: one-shot
        wr(8'h3C, 32'd4); wr(8'h34, 32'h0); wr(8'h30, 32'h01);
        sys_ticks(4);
        rd("R6 count at compare", 8'h38, 32'd4);
        rd("R6 enable cleared", 8'h30, 32'h00);
        rd("R9 pending without enable", 8'h08, 32'h04);
        check("R11 irq masked", {31'b0, irq}, 32'h0);
        sys_ticks(2);
        rd("R6 stopped", 8'h38, 32'd4);
        wr(8'h00, 32'h04);
        check("R11 irq raised", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h00);
        check("R11 irq dropped", {31'b0, irq}, 32'h0);

        // R7 channel 4: repeat
        wr(8'h4C, 32'd3); wr(8'h44, 32'h0); wr(8'h40, 32'h11);
        sys_ticks(3);
        rd("R7 restart", 8'h48, 32'd0);
        rd("R7 pending", 8'h08, 32'h0C);
        rd("R7 still enabled", 8'h40, 32'h11);
        sys_ticks(2);
        rd("R7 counting on", 8'h48, 32'd2);
        // R10 match and acknowledge in the same cycle
        @(negedge clk);
        tick_sys = 1'b1; reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h08;
        @(negedge clk);
        tick_sys = 1'b0; reg_wr = 1'b0;
        rd("R10 set wins", 8'h08, 32'h0C);
        wr(8'h08, 32'h04);
        rd("R10 partial ack", 8'h08, 32'h08);
        wr(8'h08, 32'h3F);
        rd("R10 ack all", 8'h08, 32'h00);
        wr(8'h00, 32'h08);
        check("R11 no pending", {31'b0, irq}, 32'h0);
        sys_ticks(3);
        check("R11 pending and enabled", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0); wr(8'h08, 32'h3F); wr(8'h40, 32'h0);

        // R8 channel 5: free-running, wraps at 2^10
        wr(8'h5C, 32'd2); wr(8'h54, 32'h0); wr(8'h50, 32'h31);
        sys_ticks(3);
        rd("R8 passes compare", 8'h58, 32'd3);
        rd("R8 pending", 8'h08, 32'h10);
        rd("R8 still enabled", 8'h50, 32'h31);
        sys_ticks(1021);
        rd("R8 wrap", 8'h58, 32'd0);
        wr(8'h50, 32'h0); wr(8'h08, 32'h3F);

        // R8 channel 6: spare mode code 2 runs free
        wr(8'h6C, 32'd1); wr(8'h64, 32'h0); wr(8'h60, 32'h21);
        sys_ticks(2);
        rd("R8 code 2 count", 8'h68, 32'd2);
        rd("R8 code 2 pending", 8'h08, 32'h20);
        rd("R8 code 2 ctrl", 8'h60, 32'h21);

        done = 1'b1;
        finish_run();
    end

endmodule